// File: doc/BRIEF.md
# Prefixed Vector Loop Sequencer

This block sits between instruction decode and issue. A decoded scalar operation that carries a vector prefix is turned into a run of ordinary scalar micro-operations, one per element. The run is issued in strictly ascending element order, so later stages see the same order they would see if the loop had been unrolled into separate instructions. While the run is in progress the block holds the program counter. It lets the counter move on with a one-cycle retire pulse after the final element has been dealt with. An operation without the prefix goes through as a single issue with no hold.

There are no vector registers. Vector operands are laid out on an enlarged scalar register file with 128 entries and 7-bit indices. Element `i` of a vector operand whose base is `r` uses register `r+i`. A scalar operand keeps its register for every element. The element count comes from a vector-length register that a separate write port loads. An optional per-element predicate mask can suppress individual elements. A run that would step past register 127 is refused with an illegal-instruction pulse.

Top module: `vloop_seq`

## Requirements
- R1: An operation with `dec_prefixed` low is issued exactly once. Its opcode, element width and three register numbers are unchanged, `iss_elem` is 0, `pc_hold` stays low, and `retire` pulses in the cycle after its issue handshake.
- R2: A cycle with `vl_wr` high loads the vector length, which is 0 after reset. A value above MAX_VL (16) is saturated to MAX_VL. The new length applies only to operations accepted on later cycles, and a run already in progress keeps its length.
- R3: A prefixed operation accepted with vector length n (n > 0) issues elements 0 to n-1 in ascending order, one per issue handshake (`iss_valid` and `iss_ready` both high). While `iss_ready` is low, the element and all issue fields hold.
- R4: Operand-select bit 0 stands for the destination, bit 1 for source A and bit 2 for source B. For a selected (vector) operand with base r, element i carries register r+i. An unselected operand carries r on every element.
- R5: For a prefixed operation, `pc_hold` is high from the cycle after acceptance until the last element completes. In the next cycle `retire` is high for one cycle and `pc_hold` is low.
- R6: A prefixed operation accepted while the vector length is 0 issues nothing, never raises `pc_hold`, and pulses `retire` in the cycle after acceptance.
- R7: If any vector operand would need a register above 127 (base + length - 1 > 127), the operation issues nothing and raises neither `pc_hold` nor `retire`. `illegal` pulses in the cycle after acceptance. An out-of-range base on a scalar operand is not an error.
- R8: When `dec_pred_en` is high, an element whose bit in `dec_pred_mask` (bit i for element i) is 0 is not issued. It takes one cycle, and the element index still moves on. An all-zero mask retires after exactly length cycles with no issue.
- R9: `dec_ready` is high exactly when no operation is in progress. An operation is accepted on a clock edge where `dec_valid` and `dec_ready` are both high.
- R10: The element-width code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) given with the operation appears on `iss_ew` for every element issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_wr | input | 1 | Vector-length write strobe |
| vl_wr_len | input | VL_W (5) | Requested vector length |
| dec_valid | input | 1 | Decoded operation present |
| dec_ready | output | 1 | Block can accept an operation |
| dec_prefixed | input | 1 | Operation carries the vector prefix |
| dec_opcode | input | OP_W (16) | Scalar opcode |
| dec_rd | input | REG_W (7) | Destination base register |
| dec_ra | input | REG_W (7) | Source A base register |
| dec_rb | input | REG_W (7) | Source B base register |
| dec_vec_sel | input | 3 | Per-operand vector select (bit0 rd, bit1 ra, bit2 rb) |
| dec_ew | input | 2 | Element-width code |
| dec_pred_en | input | 1 | Predicate mask enabled |
| dec_pred_mask | input | MAX_VL (16) | Per-element enable bits |
| iss_valid | output | 1 | Element micro-operation valid |
| iss_ready | input | 1 | Issue stage accepts |
| iss_opcode | output | OP_W (16) | Opcode of the element |
| iss_rd | output | REG_W (7) | Destination register of the element |
| iss_ra | output | REG_W (7) | Source A register of the element |
| iss_rb | output | REG_W (7) | Source B register of the element |
| iss_ew | output | 2 | Element-width code |
| iss_elem | output | IDX_W (4) | Element index |
| pc_hold | output | 1 | Program counter must not advance |
| retire | output | 1 | One-cycle pulse: operation finished, PC may advance |
| illegal | output | 1 | One-cycle pulse: register range exceeded |

## Verification
The first element appears on the issue outputs in the cycle after the decode edge. Each following element, or the next step past a skipped one, appears one cycle after the edge that completed the previous one. `retire` or `illegal` shows up one cycle after the final step, or one cycle after acceptance when nothing is issued. The bench drives every input on the falling edge and samples 1 ns later. As a result, each sample sees the state that the preceding rising edge registered. For every sample it predicts `pc_hold`, `dec_ready` and the expected element from its own model of the requirements. It records the cycle of the last handshake, so the retire cycle can be checked to the exact count, including trailing skipped elements.

// File: rtl/vloop_pkg.sv
`timescale 1ns/1ps
package vloop_pkg;
    localparam int unsigned NUM_OPS = 3;
    localparam int unsigned OPI_RD  = 0;
    localparam int unsigned OPI_RA  = 1;
    localparam int unsigned OPI_RB  = 2;

    typedef enum logic [1:0] {
        EW_B8  = 2'd0,
        EW_B16 = 2'd1,
        EW_B32 = 2'd2,
        EW_B64 = 2'd3
    } elem_width_e;
endpackage

// File: rtl/vloop_opmap.sv
`timescale 1ns/1ps
// Register number of one operand for the current element.
module vloop_opmap #(
    parameter int unsigned REG_W = 7,
    parameter int unsigned IDX_W = 4
) (
    input  logic [REG_W-1:0] base_i,
    input  logic             is_vec_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [REG_W-1:0] reg_o
);
    always_comb begin
        reg_o = is_vec_i ? (base_i + REG_W'(idx_i)) : base_i;
    end
endmodule

// File: rtl/vloop_range.sv
`timescale 1ns/1ps
// Flags a run whose last vector register lies past the top of the file.
module vloop_range #(
    parameter int unsigned REG_W = 7,
    parameter int unsigned VL_W  = 5,
    parameter int unsigned N_OPS = 3
) (
    input  logic [N_OPS-1:0][REG_W-1:0] base_i,
    input  logic [N_OPS-1:0]            is_vec_i,
    input  logic [VL_W-1:0]             vl_i,
    output logic                        over_o
);
    localparam int unsigned SUM_W = ((REG_W > VL_W) ? REG_W : VL_W) + 1;
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(1) << REG_W;

    logic [N_OPS-1:0] hit;

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        logic [SUM_W-1:0] span;
        assign span   = SUM_W'(base_i[g]) + SUM_W'(vl_i);
        assign hit[g] = is_vec_i[g] && (span > LIMIT);
    end

    assign over_o = |hit;
endmodule

// File: rtl/vloop_elem_sel.sv
`timescale 1ns/1ps
// Predicate lookup and end-of-run detection for the current element.
module vloop_elem_sel #(
    parameter int unsigned MAX_VL = 16,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned VL_W   = 5
) (
    input  logic              pred_en_i,
    input  logic [MAX_VL-1:0] pred_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [VL_W-1:0]   len_i,
    output logic              elem_en_o,
    output logic              last_o
);
    always_comb begin
        elem_en_o = !pred_en_i || pred_i[idx_i];
        last_o    = (VL_W'(idx_i) + VL_W'(1)) == len_i;
    end
endmodule

// File: rtl/vloop_seq.sv
`timescale 1ns/1ps
module vloop_seq
    import vloop_pkg::*;
#(
    parameter int unsigned REG_W  = 7,
    parameter int unsigned OP_W   = 16,
    parameter int unsigned MAX_VL = 16,
    localparam int unsigned VL_W  = $clog2(MAX_VL + 1),
    localparam int unsigned IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vl_wr,
    input  logic [VL_W-1:0]   vl_wr_len,
    input  logic              dec_valid,
    output logic              dec_ready,
    input  logic              dec_prefixed,
    input  logic [OP_W-1:0]   dec_opcode,
    input  logic [REG_W-1:0]  dec_rd,
    input  logic [REG_W-1:0]  dec_ra,
    input  logic [REG_W-1:0]  dec_rb,
    input  logic [2:0]        dec_vec_sel,
    input  logic [1:0]        dec_ew,
    input  logic              dec_pred_en,
    input  logic [MAX_VL-1:0] dec_pred_mask,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_opcode,
    output logic [REG_W-1:0]  iss_rd,
    output logic [REG_W-1:0]  iss_ra,
    output logic [REG_W-1:0]  iss_rb,
    output logic [1:0]        iss_ew,
    output logic [IDX_W-1:0]  iss_elem,
    output logic              pc_hold,
    output logic              retire,
    output logic              illegal
);
    localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

    typedef struct packed {
        logic                              busy;
        logic                              vec;
        logic [IDX_W-1:0]                  idx;
        logic [VL_W-1:0]                   len;
        logic [OP_W-1:0]                   opc;
        logic [NUM_OPS-1:0][REG_W-1:0]     base;
        logic [NUM_OPS-1:0]                vsel;
        elem_width_e                       ew;
        logic                              pred_en;
        logic [MAX_VL-1:0]                 pred;
        logic                              retire;
        logic                              illegal;
        logic [VL_W-1:0]                   vl;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [NUM_OPS-1:0][REG_W-1:0] dec_base;
    logic [NUM_OPS-1:0][REG_W-1:0] cur_reg;
    logic                          range_bad;
    logic                          elem_en;
    logic                          elem_last;
    logic                          step;
    logic [VL_W-1:0]               vl_clamped;

    always_comb begin
        dec_base[OPI_RD] = dec_rd;
        dec_base[OPI_RA] = dec_ra;
        dec_base[OPI_RB] = dec_rb;
    end

    vloop_range #(
        .REG_W (REG_W),
        .VL_W  (VL_W),
        .N_OPS (NUM_OPS)
    ) u_range (
        .base_i   (dec_base),
        .is_vec_i (dec_vec_sel),
        .vl_i     (st_q.vl),
        .over_o   (range_bad)
    );

    vloop_elem_sel #(
        .MAX_VL (MAX_VL),
        .IDX_W  (IDX_W),
        .VL_W   (VL_W)
    ) u_elem_sel (
        .pred_en_i (st_q.pred_en),
        .pred_i    (st_q.pred),
        .idx_i     (st_q.idx),
        .len_i     (st_q.len),
        .elem_en_o (elem_en),
        .last_o    (elem_last)
    );

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_map
        vloop_opmap #(
            .REG_W (REG_W),
            .IDX_W (IDX_W)
        ) u_opmap (
            .base_i   (st_q.base[g]),
            .is_vec_i (st_q.vsel[g]),
            .idx_i    (st_q.idx),
            .reg_o    (cur_reg[g])
        );
    end

    always_comb begin
        vl_clamped = (vl_wr_len > VL_CAP) ? VL_CAP : vl_wr_len;
        step       = st_q.busy && (!elem_en || iss_ready);

        st_d         = st_q;
        st_d.retire  = 1'b0;
        st_d.illegal = 1'b0;

        if (vl_wr) begin
            st_d.vl = vl_clamped;
        end

        if (st_q.busy) begin
            if (step) begin
                if (elem_last) begin
                    st_d.busy   = 1'b0;
                    st_d.vec    = 1'b0;
                    st_d.idx    = '0;
                    st_d.retire = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + IDX_W'(1);
                end
            end
        end else if (dec_valid) begin
            st_d.opc  = dec_opcode;
            st_d.base = dec_base;
            st_d.ew   = elem_width_e'(dec_ew);
            st_d.idx  = '0;
            if (!dec_prefixed) begin
                st_d.busy    = 1'b1;
                st_d.vec     = 1'b0;
                st_d.len     = VL_W'(1);
                st_d.vsel    = '0;
                st_d.pred_en = 1'b0;
            end else if (st_q.vl == '0) begin
                st_d.retire = 1'b1;
            end else if (range_bad) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.busy    = 1'b1;
                st_d.vec     = 1'b1;
                st_d.len     = st_q.vl;
                st_d.vsel    = dec_vec_sel;
                st_d.pred_en = dec_pred_en;
                st_d.pred    = dec_pred_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        dec_ready  = !st_q.busy;
        iss_valid  = st_q.busy && elem_en;
        iss_opcode = st_q.opc;
        iss_rd     = cur_reg[OPI_RD];
        iss_ra     = cur_reg[OPI_RA];
        iss_rb     = cur_reg[OPI_RB];
        iss_ew     = st_q.ew;
        iss_elem   = st_q.idx;
        pc_hold    = st_q.busy && st_q.vec;
        retire     = st_q.retire;
        illegal    = st_q.illegal;
    end
endmodule

// File: rtl/vloop_seq_chk.sv
`timescale 1ns/1ps
module vloop_seq_chk #(
    parameter int unsigned REG_W = 7,
    parameter int unsigned OP_W  = 16,
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_ready,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [OP_W-1:0]  iss_opcode,
    input logic [REG_W-1:0] iss_rd,
    input logic [REG_W-1:0] iss_ra,
    input logic [REG_W-1:0] iss_rb,
    input logic [1:0]       iss_ew,
    input logic [IDX_W-1:0] iss_elem,
    input logic             pc_hold,
    input logic             retire,
    input logic             illegal
);
    // R3
    iss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !iss_ready |=> iss_valid && $stable(iss_elem) && $stable(iss_rd)
            && $stable(iss_ra) && $stable(iss_rb) && $stable(iss_opcode) && $stable(iss_ew));

    // R3
    elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && iss_ready |=> !iss_valid || (iss_elem > $past(iss_elem)));

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid || pc_hold) |-> !dec_ready);

    // R5
    retire_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> !pc_hold && !iss_valid);

    // R5
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pc_hold) |-> retire);

    // R7
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !retire && !iss_valid && !pc_hold);

    // R1
    scalar_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid && !pc_hold |-> iss_elem == '0);
endmodule

bind vloop_seq vloop_seq_chk #(
    .REG_W (REG_W),
    .OP_W  (OP_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_ready  (dec_ready),
    .iss_valid  (iss_valid),
    .iss_ready  (iss_ready),
    .iss_opcode (iss_opcode),
    .iss_rd     (iss_rd),
    .iss_ra     (iss_ra),
    .iss_rb     (iss_rb),
    .iss_ew     (iss_ew),
    .iss_elem   (iss_elem),
    .pc_hold    (pc_hold),
    .retire     (retire),
    .illegal    (illegal)
);

// File: tb/vloop_seq_bench.sv
`timescale 1ns/1ps
module vloop_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        vl_wr;
    logic [4:0]  vl_wr_len;
    logic        dec_valid;
    logic        dec_ready;
    logic        dec_prefixed;
    logic [15:0] dec_opcode;
    logic [6:0]  dec_rd, dec_ra, dec_rb;
    logic [2:0]  dec_vec_sel;
    logic [1:0]  dec_ew;
    logic        dec_pred_en;
    logic [15:0] dec_pred_mask;
    logic        iss_valid;
    logic        iss_ready;
    logic [15:0] iss_opcode;
    logic [6:0]  iss_rd, iss_ra, iss_rb;
    logic [1:0]  iss_ew;
    logic [3:0]  iss_elem;
    logic        pc_hold, retire, illegal;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vloop_seq u_vloop_seq (
        .clk(clk), .rst_n(rst_n), .vl_wr(vl_wr), .vl_wr_len(vl_wr_len),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_prefixed(dec_prefixed),
        .dec_opcode(dec_opcode), .dec_rd(dec_rd), .dec_ra(dec_ra), .dec_rb(dec_rb),
        .dec_vec_sel(dec_vec_sel), .dec_ew(dec_ew), .dec_pred_en(dec_pred_en),
        .dec_pred_mask(dec_pred_mask), .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_opcode(iss_opcode), .iss_rd(iss_rd), .iss_ra(iss_ra), .iss_rb(iss_rb),
        .iss_ew(iss_ew), .iss_elem(iss_elem), .pc_hold(pc_hold), .retire(retire),
        .illegal(illegal)
    );

    typedef struct packed {
        logic        pfx;
        logic [4:0]  vl;
        logic [6:0]  rd;
        logic [6:0]  ra;
        logic [6:0]  rb;
        logic [2:0]  vsel;
        logic [1:0]  ew;
        logic        pen;
        logic [15:0] pred;
        logic [3:0]  rdy;
        logic [4:0]  exp_n;
        logic        exp_ill;
    } case_t;

    localparam int NCASE = 11;
    localparam case_t CASES [NCASE] = '{
        // scalar pass-through (R1)
        '{1'b0, 5'd3,  7'd5,   7'd6,   7'd7,   3'b000, 2'd3, 1'b0, 16'h0000, 4'b1111, 5'd4 - 5'd3, 1'b0},
        // rd, ra vector, rb scalar (R4)
        '{1'b1, 5'd4,  7'd10,  7'd20,  7'd3,   3'b011, 2'd2, 1'b0, 16'h0000, 4'b1111, 5'd4,  1'b0},
        // all vector, back-pressure (R3)
        '{1'b1, 5'd5,  7'd0,   7'd40,  7'd100, 3'b111, 2'd0, 1'b0, 16'h0000, 4'b0101, 5'd5,  1'b0},
        // predicate 0xA5 over 8 elements (R8)
        '{1'b1, 5'd8,  7'd30,  7'd1,   7'd2,   3'b001, 2'd1, 1'b1, 16'h00A5, 4'b1111, 5'd4,  1'b0},
        // all-zero predicate (R8)
        '{1'b1, 5'd6,  7'd30,  7'd1,   7'd2,   3'b001, 2'd1, 1'b1, 16'h0000, 4'b1111, 5'd0,  1'b0},
        // length zero (R6)
        '{1'b1, 5'd0,  7'd9,   7'd9,   7'd9,   3'b111, 2'd0, 1'b0, 16'h0000, 4'b1111, 5'd0,  1'b0},
        // rd 125 + 3 past 127 (R7)
        '{1'b1, 5'd4,  7'd125, 7'd1,   7'd2,   3'b001, 2'd3, 1'b0, 16'h0000, 4'b1111, 5'd0,  1'b1},
        // rd 124 + 3 = 127 fits (R7)
        '{1'b1, 5'd4,  7'd124, 7'd1,   7'd2,   3'b001, 2'd3, 1'b0, 16'h0000, 4'b1111, 5'd4,  1'b0},
        // high scalar rb is no error (R7)
        '{1'b1, 5'd8,  7'd1,   7'd2,   7'd126, 3'b001, 2'd2, 1'b0, 16'h0000, 4'b1111, 5'd8,  1'b0},
        // length 25 saturates to 16 (R2)
        '{1'b1, 5'd25, 7'd3,   7'd50,  7'd4,   3'b010, 2'd1, 1'b0, 16'h0000, 4'b1011, 5'd16, 1'b0},
        // ra 113 + 15 past 127 (R7)
        '{1'b1, 5'd16, 7'd3,   7'd113, 7'd4,   3'b010, 2'd1, 1'b0, 16'h0000, 4'b1111, 5'd0,  1'b1}
    };

    localparam case_t RST_CASE = '{1'b1, 5'd0, 7'd8, 7'd8, 7'd8, 3'b111, 2'd0, 1'b0, 16'h0, 4'b1111, 5'd0, 1'b0};
    localparam case_t MID_CASE = '{1'b1, 5'd4, 7'd60, 7'd1, 7'd2, 3'b001, 2'd2, 1'b0, 16'h0, 4'b1111, 5'd4, 1'b0};
    localparam case_t FOL_CASE = '{1'b1, 5'd2, 7'd1, 7'd70, 7'd2, 3'b010, 2'd2, 1'b0, 16'h0, 4'b1111, 5'd2, 1'b0};

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit elem_on(input case_t c, input int i);
        return !c.pfx || !c.pen || c.pred[i];
    endfunction

    function automatic int next_on(input case_t c, input int from, input int eff);
        for (int i = from; i < eff; i++) begin
            if (elem_on(c, i)) return i;
        end
        return eff;
    endfunction

    task automatic run_case(input int id, input case_t c, input bit do_wr, input bit mid_wr);
        int eff_vl, exp_elem, n_iss, ret_cyc, fire_cyc, last_en, e_rd, e_ra, e_rb;
        bit saw_ret, saw_ill;
        eff_vl = !c.pfx ? 1 : ((c.vl > 5'd16) ? 16 : int'(c.vl));
        last_en = -1;
        for (int i = 0; i < eff_vl; i++) begin
            if (elem_on(c, i)) last_en = i;
        end
        if (do_wr) begin
            @(negedge clk);
            vl_wr = 1'b1;
            vl_wr_len = c.vl;
        end
        @(negedge clk);
        vl_wr = 1'b0;
        dec_prefixed = c.pfx;
        dec_opcode = 16'hA000 + 16'(id);
        dec_rd = c.rd; dec_ra = c.ra; dec_rb = c.rb;
        dec_vec_sel = c.vsel; dec_ew = c.ew;
        dec_pred_en = c.pen; dec_pred_mask = c.pred;
        dec_valid = 1'b1;
        #1;
        chk(dec_ready == 1'b1, "R9", "dec_ready idle", int'(dec_ready), 1);
        @(negedge clk);
        dec_valid = 1'b0;
        exp_elem = next_on(c, 0, eff_vl);
        n_iss = 0; saw_ret = 0; saw_ill = 0; ret_cyc = -1; fire_cyc = -1;
        for (int cyc = 0; cyc < 80; cyc++) begin
            iss_ready = c.rdy[cyc % 4];
            vl_wr = mid_wr && (cyc == 1);
            vl_wr_len = 5'd2;
            #1;
            chk(pc_hold == (c.pfx && !retire && !illegal), "R5", "pc_hold",
                int'(pc_hold), int'(c.pfx && !retire && !illegal));
            chk(dec_ready == (retire || illegal), "R9", "dec_ready busy",
                int'(dec_ready), int'(retire || illegal));
            if (iss_valid && iss_ready) begin
                e_rd = c.vsel[0] ? ((int'(c.rd) + exp_elem) % 128) : int'(c.rd);
                e_ra = c.vsel[1] ? ((int'(c.ra) + exp_elem) % 128) : int'(c.ra);
                e_rb = c.vsel[2] ? ((int'(c.rb) + exp_elem) % 128) : int'(c.rb);
                chk(int'(iss_elem) == exp_elem, "R8", "element order", int'(iss_elem), exp_elem);
                chk(int'(iss_rd) == e_rd, "R4", "iss_rd", int'(iss_rd), e_rd);
                chk(int'(iss_ra) == e_ra, "R4", "iss_ra", int'(iss_ra), e_ra);
                chk(int'(iss_rb) == e_rb, "R4", "iss_rb", int'(iss_rb), e_rb);
                chk(iss_opcode == 16'hA000 + 16'(id), "R1", "iss_opcode",
                    int'(iss_opcode), 32'hA000 + id);
                chk(iss_ew == c.ew, "R10", "iss_ew", int'(iss_ew), int'(c.ew));
                n_iss++;
                fire_cyc = cyc;
                exp_elem = next_on(c, exp_elem + 1, eff_vl);
            end
            if (retire || illegal) begin
                saw_ret = retire;
                saw_ill = illegal;
                ret_cyc = cyc;
                break;
            end
            @(negedge clk);
        end
        vl_wr = 1'b0;
        iss_ready = 1'b0;
        chk(n_iss == int'(c.exp_n), "R3", "issue count", n_iss, int'(c.exp_n));
        chk(saw_ill == c.exp_ill, "R7", "illegal pulse", int'(saw_ill), int'(c.exp_ill));
        chk(saw_ret == !c.exp_ill, "R5", "retire pulse", int'(saw_ret), int'(!c.exp_ill));
        if (c.exp_ill || eff_vl == 0) begin
            chk(ret_cyc == 0, "R6", "end cycle without issue", ret_cyc, 0);
        end else if (last_en >= 0) begin
            chk(ret_cyc == fire_cyc + 1 + (eff_vl - 1 - last_en), "R5", "retire cycle",
                ret_cyc, fire_cyc + 1 + (eff_vl - 1 - last_en));
        end else begin
            chk(ret_cyc == eff_vl, "R8", "retire after skipped run", ret_cyc, eff_vl);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        vl_wr = 1'b0; vl_wr_len = '0;
        dec_valid = 1'b0; dec_prefixed = 1'b0; dec_opcode = '0;
        dec_rd = '0; dec_ra = '0; dec_rb = '0; dec_vec_sel = '0; dec_ew = '0;
        dec_pred_en = 1'b0; dec_pred_mask = '0;
        iss_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state (R9, R5)
        chk(dec_ready == 1'b1, "R9", "reset dec_ready", int'(dec_ready), 1);
        chk(iss_valid == 1'b0, "R3", "reset iss_valid", int'(iss_valid), 0);
        chk(pc_hold == 1'b0, "R5", "reset pc_hold", int'(pc_hold), 0);
        chk(retire == 1'b0, "R5", "reset retire", int'(retire), 0);
        chk(illegal == 1'b0, "R7", "reset illegal", int'(illegal), 0);

        // R2: vector length is 0 after reset, so nothing is issued
        run_case(100, RST_CASE, 1'b0, 1'b0);

        for (int k = 0; k < NCASE; k++) begin
            run_case(k, CASES[k], 1'b1, 1'b0);
        end

        // R2: length write during a run leaves it intact, applies to the next one
        run_case(101, MID_CASE, 1'b1, 1'b1);
        run_case(102, FOL_CASE, 1'b0, 1'b0);

        // R1: scalar right after a vector run
        run_case(103, CASES[0], 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule